// File: doc/BRIEF.md
# Bus Access Timeout Monitor

This block sits beside a processor-style register bus and watches every access. When a request begins, a cycle counter on the processor clock starts from zero. If no internal target acknowledges before the counter reaches the programmed limit, the access is declared failed. A one-cycle event pulse is raised and the word address of that access is kept for software to read later. If enabled, the block also closes the access with a generated acknowledge, so that the bus master does not hang.

Target acknowledges are merged with the generated acknowledge into a single forwarded acknowledge. The timeout limit is held in a small register. It is written through a load strobe and comes out of reset at its maximum value. Register decode and read-data steering belong to the surrounding logic.

Top module: `bus_timeout_mon`

## Requirements
- R1: After reset, `ack_out`, `gen_ack` and `tmo_pulse` are 0 and `last_addr` is 0.
- R2: After reset, the timeout limit is 511 with default parameters. A request with no target acknowledge expires in the cycle when 511 clock periods have passed since the edge that captured `req_start`.
- R3: Asserting `cfg_load` writes `cfg_count` into the limit at the clock edge. Limit L makes an unacknowledged request expire in the cycle when L periods have passed since the capturing edge. L = 0 expires in the first cycle after capture. If L is written below the current count while a request is pending, that request expires at once.
- R4: With `cfg_ack_en` = 1, an expiring request drives `gen_ack` high for exactly that one cycle.
- R5: With `cfg_ack_en` = 0, `gen_ack` stays 0 at expiry, and `tmo_pulse` and the address capture still occur.
- R6: At expiry, `tmo_pulse` is high for one cycle. From the next cycle, `last_addr` holds the word address of the expired request. The word address is `req_addr` shifted right by `WORD_LSB` bits, which is bit 0 with the defaults.
- R7: `ack_out` is the OR of all `tgt_ack` bits and `gen_ack`, with no added latency.
- R8: A target acknowledge during a pending request ends it, and no later expiry follows. A new `req_start` while a request is pending restarts the count from zero and replaces the stored address.
- R9: If a target acknowledge arrives in the cycle when expiry would occur, `tmo_pulse` and `gen_ack` stay 0 and `last_addr` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | One-cycle strobe marking a new bus request |
| req_addr | input | ADDR_W | Byte address of the request, sampled with `req_start` |
| tgt_ack | input | N_TGT | Acknowledges from the internal targets |
| cfg_load | input | 1 | Write strobe for the timeout limit |
| cfg_count | input | CNT_W | New timeout limit in clock periods |
| cfg_ack_en | input | 1 | 1: close timed-out accesses with a generated acknowledge |
| ack_out | output | 1 | Merged acknowledge toward the bus master |
| gen_ack | output | 1 | Generated acknowledge on timeout |
| tmo_pulse | output | 1 | One-cycle timeout event |
| last_addr | output | ADDR_W-WORD_LSB | Word address of the most recent timed-out request |

## Verification
The request function is tried with three kinds of traffic: accesses left unanswered, accesses answered early, and accesses answered in exactly the expiry cycle. Between them, these separate a counter that stops correctly from one that keeps running, and show that a target acknowledge takes priority over a timeout. Limits of 0, small values, the reset value 511, and a limit lowered while a request is pending check the counting boundaries. The acknowledge-enable setting is toggled so that the generated acknowledge can be told apart from the event pulse and the address capture. A request restarted while another is pending shows whether the count and the stored address are replaced.

// File: rtl/bto_pkg.sv
package bto_pkg;
   localparam int unsigned BTO_CNT_W_DEF  = 9;
   localparam int unsigned BTO_ADDR_W_DEF = 16;
   typedef enum logic { BTO_IDLE = 1'b0, BTO_WAIT = 1'b1 } bto_state_e;
endpackage

// File: rtl/bto_counter.sv
module bto_counter #(
   parameter int unsigned CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic             lim_load,
   input  logic [CNT_W-1:0] lim_val,
   output logic             pending,
   output logic             expire
);
   import bto_pkg::*;
   localparam logic [CNT_W-1:0] LIM_RST = {CNT_W{1'b1}};

   bto_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;

   assign pending = (state == BTO_WAIT);
   assign expire  = pending && !stop && (cnt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         limit <= LIM_RST;
      end else if (lim_load) begin
         limit <= lim_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= BTO_IDLE;
         cnt   <= '0;
      end else if (start) begin
         state <= BTO_WAIT;
         cnt   <= '0;
      end else if (pending && (stop || expire)) begin
         state <= BTO_IDLE;
      end else if (pending) begin
         cnt <= cnt + 1'b1;
      end
   end

   // R8: a target acknowledge without a new request closes the request
   a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && stop && !start) |=> !pending);
   // R3: a request never stays pending once the count passes the limit
   a_r3_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !start && (cnt >= limit)) |=> !pending);
endmodule

// File: rtl/bto_capture.sv
module bto_capture #(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned WORD_LSB = 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [ADDR_W-1:0]          addr,
   input  logic                       expire,
   output logic [ADDR_W-WORD_LSB-1:0] last_word
);
   localparam int unsigned WW = ADDR_W - WORD_LSB;

   logic [WW-1:0] cur_word;
   logic [WW-1:0] word_in;

   generate
      if (WORD_LSB == 0) begin : g_byte
         assign word_in = addr;
      end else begin : g_word
         assign word_in = addr[ADDR_W-1:WORD_LSB];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_word  <= '0;
         last_word <= '0;
      end else begin
         if (expire) last_word <= cur_word;
         if (start)  cur_word  <= word_in;
      end
   end

   // R6: an expiry loads the stored request address into the readback
   a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (last_word == $past(cur_word)));
   // R9: no expiry means the readback holds
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !expire |=> $stable(last_word));
endmodule

// File: rtl/bus_timeout_mon.sv
module bus_timeout_mon #(
   parameter int unsigned CNT_W    = bto_pkg::BTO_CNT_W_DEF,
   parameter int unsigned ADDR_W   = bto_pkg::BTO_ADDR_W_DEF,
   parameter int unsigned WORD_LSB = 1,
   parameter int unsigned N_TGT    = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_start,
   input  logic [ADDR_W-1:0]          req_addr,
   input  logic [N_TGT-1:0]           tgt_ack,
   input  logic                       cfg_load,
   input  logic [CNT_W-1:0]           cfg_count,
   input  logic                       cfg_ack_en,
   output logic                       ack_out,
   output logic                       gen_ack,
   output logic                       tmo_pulse,
   output logic [ADDR_W-WORD_LSB-1:0] last_addr
);
   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W out of range");
      end
      if (WORD_LSB >= ADDR_W) begin : g_bad_lsb
         $error("WORD_LSB must be below ADDR_W");
      end
      if (N_TGT < 1) begin : g_bad_tgt
         $error("N_TGT must be at least 1");
      end
   endgenerate

   logic any_ack;
   logic pending;
   logic expire;

   assign any_ack = |tgt_ack;

   bto_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (req_start),
      .stop     (any_ack),
      .lim_load (cfg_load),
      .lim_val  (cfg_count),
      .pending  (pending),
      .expire   (expire)
   );

   bto_capture #(.ADDR_W(ADDR_W), .WORD_LSB(WORD_LSB)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (req_start),
      .addr      (req_addr),
      .expire    (expire),
      .last_word (last_addr)
   );

   assign tmo_pulse = expire;
   assign gen_ack   = expire && cfg_ack_en;
   assign ack_out   = any_ack || gen_ack;

   // R4: a generated acknowledge only ever closes a pending request
   a_r4_gen_pending: assert property (@(posedge clk) disable iff (!rst_n)
      gen_ack |-> pending);
   // R9: a target acknowledge suppresses the timeout event
   a_r9_tgt_wins: assert property (@(posedge clk) disable iff (!rst_n)
      any_ack |-> !tmo_pulse);
   // R6: the event lasts one cycle unless a new request is captured
   a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_pulse && !req_start) |=> !tmo_pulse);
   // R5: with generation disabled no acknowledge is produced
   a_r5_no_gen: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_ack_en |-> !gen_ack);
endmodule

// File: tb/sim_bus_timeout_mon.sv
module sim_bus_timeout_mon;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_start = 1'b0;
   logic [15:0] req_addr = '0;
   logic [3:0]  tgt_ack = '0;
   logic        cfg_load = 1'b0;
   logic [8:0]  cfg_count = '0;
   logic        cfg_ack_en = 1'b0;
   logic        ack_out, gen_ack, tmo_pulse;
   logic [14:0] last_addr;

   int total = 0;
   int bad = 0;
   bit done = 0;

   int m_limit = 511;
   bit m_pend = 0;
   int m_el = 0;
   int m_cur = 0;
   int m_last = 0;

   always #5 clk = ~clk;

   bus_timeout_mon u0 (.*);

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // drive one cycle: set inputs at negedge, compare, then update the model at posedge
   task automatic step(input bit st, input int addr, input int ack,
                       input bit ld, input int lv, input bit en);
      bit any, ex;
      req_start = st; req_addr = 16'(addr); tgt_ack = 4'(ack);
      cfg_load = ld; cfg_count = 9'(lv); cfg_ack_en = en;
      #1;
      any = (ack != 0);
      ex  = m_pend && !any && (m_el >= m_limit);
      chk("R7 ack_out", int'(ack_out), int'(any || (ex && en)));
      chk("R4/R5 gen_ack", int'(gen_ack), int'(ex && en));
      chk("R6/R9 tmo_pulse", int'(tmo_pulse), int'(ex));
      chk("R6 last_addr", int'(last_addr), m_last);
      @(posedge clk);
      if (ex) m_last = m_cur;
      if (ld) m_limit = lv;
      if (st) begin m_pend = 1; m_el = 0; m_cur = addr >> 1; end
      else if (m_pend && (any || ex)) m_pend = 0;
      else if (m_pend) m_el++;
      @(negedge clk);
   endtask

   task automatic idle(input int n, input bit en);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, en);
   endtask

   initial begin
      #3;
      // R1: reset state
      chk("R1 ack_out", int'(ack_out), 0);
      chk("R1 gen_ack", int'(gen_ack), 0);
      chk("R1 tmo_pulse", int'(tmo_pulse), 0);
      chk("R1 last_addr", int'(last_addr), 0);
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: default limit 511, ack enabled
      step(1, 16'h1234, 0, 0, 0, 1);
      idle(510, 1);
      chk("R2 no early expiry", int'(tmo_pulse), 0);
      step(0, 0, 0, 0, 0, 1);
      #1 chk("R2 expired at 511", int'(tmo_pulse), 1);
      idle(2, 1);
      chk("R6 word address", int'(last_addr), 16'h1234 >> 1);
      // R3: limit 5
      step(0, 0, 0, 1, 5, 1);
      step(1, 16'h00A2, 0, 0, 0, 1);
      idle(8, 1);
      chk("R3 limit 5 capture", int'(last_addr), 16'h00A2 >> 1);
      // R5: ack disabled, capture still happens
      step(1, 16'h0F0E, 0, 0, 0, 0);
      idle(8, 0);
      chk("R5 capture without gen", int'(last_addr), 16'h0F0E >> 1);
      // R8: early target ack stops
      step(1, 16'h2222, 0, 0, 0, 1);
      idle(2, 1);
      step(0, 0, 4'b0100, 0, 0, 1);
      idle(10, 1);
      chk("R8 early ack no capture", int'(last_addr), 16'h0F0E >> 1);
      // R9: ack in expiry cycle
      step(1, 16'h3334, 0, 0, 0, 1);
      idle(5, 1);
      step(0, 0, 4'b0001, 0, 0, 1);
      idle(4, 1);
      chk("R9 tie keeps address", int'(last_addr), 16'h0F0E >> 1);
      // R8: restart mid-request
      step(1, 16'h4444, 0, 0, 0, 1);
      idle(3, 1);
      step(1, 16'h5556, 0, 0, 0, 1);
      idle(4, 1);
      chk("R8 restart no early expiry", int'(tmo_pulse), 0);
      idle(4, 1);
      chk("R8 restart new address", int'(last_addr), 16'h5556 >> 1);
      // R3: limit 0
      step(0, 0, 0, 1, 0, 1);
      step(1, 16'h6666, 0, 0, 0, 1);
      req_start = 0; #1;
      chk("R3 limit 0 immediate", int'(gen_ack), 1);
      idle(2, 1);
      // R3: limit lowered while pending
      step(0, 0, 0, 1, 100, 1);
      step(1, 16'h7778, 0, 0, 0, 1);
      idle(20, 1);
      step(0, 0, 0, 1, 3, 1);
      idle(3, 1);
      chk("R3 lowered limit capture", int'(last_addr), 16'h7778 >> 1);
      // R7: target ack outside a request still forwarded
      step(0, 0, 4'b1000, 0, 0, 1);
      idle(3, 1);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule